// File: doc/BRIEF.md
# Packed Color Lookup Table

The block holds a 256-entry color lookup table for a display path. A processor bus sees the table as 128 words of 32 bits. Each word packs two 16-bit color entries. In each entry, three 5-bit components sit at fixed bit positions, and a top bit marks intensity. Bus reads return the stored words unchanged. Bus reads and writes that fall outside the table window are harmless.

A separate pixel stream presents an 8-bit index and receives the matching color, one cycle later, as three 8-bit components. Each component is the 5-bit field shifted left by three places. The intensity bit is kept in storage but plays no part in the looked-up color. A plain control pin exchanges red and blue for panels that expect blue-first ordering.

The pixel stream uses valid/ready handshakes. An index is taken on any cycle where `px_in_valid` and `px_in_ready` are both high. `px_in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result that is waiting for `px_out_ready` is held unchanged until it is taken.

Top module: `color_lut`

## Requirements
- R1: A bus write whose byte address lies in 0x200..0x3FF stores the 32-bit data as word n, where n = address bits 8:2. A bus read of that address raises `bus_rvalid` on the following cycle, with `bus_rdata` equal to the stored word.
- R2: A bus write outside 0x200..0x3FF changes no table word. A bus read outside that window still answers on the following cycle, with `bus_rdata` equal to zero.
- R3: Index i reads word i>>1. An even index uses bits 15:0 of that word, and an odd index uses bits 31:16.
- R4: Within an entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Each output component is its field shifted left by 3, so bits 2:0 of every output component are zero.
- R5: Bit 15 of an entry (intensity) has no effect on the looked-up color.
- R6: An index accepted in cycle t produces `px_out_valid` and its color in cycle t+1.
- R7: `px_in_ready` equals `!px_out_valid || px_out_ready`. While `px_out_valid` is high and `px_out_ready` is low, the output color and `px_out_valid` stay unchanged.
- R8: If a bus write and an accepted lookup touch the same word in the same cycle, the lookup returns the color from before the write. Lookups from the next cycle on return the new color.
- R9: With `swap_rb` high at acceptance, the red and blue outputs are exchanged.
- R10: After reset, `px_out_valid` and `bus_rvalid` are low and every table word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| swap_rb | input | 1 | Exchange red and blue outputs |
| px_in_valid | input | 1 | Index valid |
| px_in_ready | output | 1 | Index accepted when high with valid |
| px_in_index | input | 8 | Palette index |
| px_out_valid | output | 1 | Color valid |
| px_out_ready | input | 1 | Downstream takes the color |
| px_out_red | output | 8 | Red component |
| px_out_green | output | 8 | Green component |
| px_out_blue | output | 8 | Blue component |

## Verification
Every result is due exactly one clock edge after its stimulus. Bus read data arrives in the cycle after the strobe, and a color arrives in the cycle after its index is accepted. A stalled color stays put until it is drained. The bench drives each cycle's inputs at the falling edge and advances a cycle-level model across the next rising edge. The model reads the table before it applies any write from the same cycle. The bench compares the outputs at the following falling edge, so each check lands on the one cycle where its result is due.

// File: rtl/color_lut_pkg.sv
package color_lut_pkg;
  localparam int COMP_IN_W  = 5;
  localparam int COMP_OUT_W = 8;
  localparam int ENTRY_W    = 16;

  typedef struct packed {
    logic [COMP_OUT_W-1:0] red;
    logic [COMP_OUT_W-1:0] green;
    logic [COMP_OUT_W-1:0] blue;
  } rgb_t;

  function automatic logic [COMP_OUT_W-1:0] widen(input logic [COMP_IN_W-1:0] f);
    return {f, {(COMP_OUT_W-COMP_IN_W){1'b0}}};
  endfunction
endpackage

// File: rtl/palette_store.sv
module palette_store #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_word
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_hit ? mem[rd_idx] : '0;
    end
  end

  assign lk_word = mem[lk_idx];

  // R1: a read strobe is answered on the next cycle
  a_r1_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2: a read outside the window returns zero
  a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == '0));
endmodule

// File: rtl/lookup_stage.sv
module lookup_stage
  import color_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IDX_W-1:0]       in_index,
  input  logic [2*ENTRY_W-1:0]   word,
  input  logic                   swap,
  output logic                   out_valid,
  input  logic                   out_ready,
  output rgb_t                   out_rgb
);
  logic [ENTRY_W-1:0]     entry;
  logic [COMP_OUT_W-1:0]  comp [3];
  rgb_t                   next_rgb;
  logic                   take;

  assign entry = in_index[0] ? word[2*ENTRY_W-1:ENTRY_W] : word[ENTRY_W-1:0];

  for (genvar c = 0; c < 3; c++) begin : g_comp
    assign comp[c] = widen(entry[c*COMP_IN_W +: COMP_IN_W]);
  end

  always_comb begin
    next_rgb.green = comp[1];
    next_rgb.red   = swap ? comp[2] : comp[0];
    next_rgb.blue  = swap ? comp[0] : comp[2];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_rgb   <= next_rgb;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: an accepted index yields a valid color next cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R7: a stalled result is held
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));
  // R4: expanded components have zero low bits
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rgb.red[2:0] == 3'b0 && out_rgb.green[2:0] == 3'b0
                   && out_rgb.blue[2:0] == 3'b0));
endmodule

// File: rtl/color_lut.sv
module color_lut
  import color_lut_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 128,
  parameter int BASE    = 'h200,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int SPAN_W = WIDX_W + 2,
  localparam int PIX_W  = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              swap_rb,
  input  logic              px_in_valid,
  output logic              px_in_ready,
  input  logic [PIX_W-1:0]  px_in_index,
  output logic              px_out_valid,
  input  logic              px_out_ready,
  output logic [7:0]        px_out_red,
  output logic [7:0]        px_out_green,
  output logic [7:0]        px_out_blue
);
  localparam logic [ADDR_W-SPAN_W-1:0] WIN_TAG = ADDR_W'(BASE) >> SPAN_W;

  logic              in_win;
  logic [WIDX_W-1:0] word_idx;
  logic [DATA_W-1:0] lk_word;
  rgb_t              rgb;

  assign in_win   = bus_addr[ADDR_W-1:SPAN_W] == WIN_TAG;
  assign word_idx = bus_addr[SPAN_W-1:2];

  palette_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr && in_win),
    .wr_idx   (word_idx),
    .wr_data  (bus_wdata),
    .rd_en    (bus_rd),
    .rd_hit   (in_win),
    .rd_idx   (word_idx),
    .rd_data  (bus_rdata),
    .rd_valid (bus_rvalid),
    .lk_idx   (px_in_index[PIX_W-1:1]),
    .lk_word  (lk_word)
  );

  lookup_stage #(.IDX_W(PIX_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (px_in_valid),
    .in_ready  (px_in_ready),
    .in_index  (px_in_index),
    .word      (lk_word),
    .swap      (swap_rb),
    .out_valid (px_out_valid),
    .out_ready (px_out_ready),
    .out_rgb   (rgb)
  );

  assign px_out_red   = rgb.red;
  assign px_out_green = rgb.green;
  assign px_out_blue  = rgb.blue;

  // R7: index ready rule seen at the ports
  a_r7_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (px_out_valid && !px_out_ready) |-> !px_in_ready);
  // R10: no read answer without a strobe
  a_r10_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

// File: tb/color_lut_tb.sv
module color_lut_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic swap_rb = 0, px_in_valid = 0, px_out_ready = 0;
  logic px_in_ready, px_out_valid;
  logic [7:0] px_in_index = '0;
  logic [7:0] px_out_red, px_out_green, px_out_blue;

  always #2 clk = ~clk;

  color_lut u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_mem [128];
  logic        m_ov = 0;
  logic [23:0] m_pix = '0;
  logic        m_rv = 0;
  logic [31:0] m_rd = '0;

  function automatic logic [23:0] color_of(logic [31:0] w, bit odd, bit sw);
    logic [15:0] e = odd ? w[31:16] : w[15:0];
    logic [7:0] r = {e[4:0], 3'b0};
    logic [7:0] g = {e[9:5], 3'b0};
    logic [7:0] b = {e[14:10], 3'b0};
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model across posedge, compare at next negedge
  task automatic step(bit we, bit re, logic [11:0] a, logic [31:0] wd,
                      bit iv, logic [7:0] idx, bit sw, bit ordy, string req);
    bit acc, win;
    bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = wd;
    px_in_valid = iv; px_in_index = idx; swap_rb = sw; px_out_ready = ordy;
    #1;
    chk(px_in_ready == (!m_ov || ordy), "R7 ready", 32'(px_in_ready), 32'(!m_ov || ordy));
    win = (a[11:9] == 3'b001);
    acc = iv && (!m_ov || ordy);
    if (acc) begin m_ov = 1; m_pix = color_of(m_mem[idx[7:1]], idx[0], sw); end
    else if (ordy) m_ov = 0;
    m_rv = re;
    if (re) m_rd = win ? m_mem[a[8:2]] : 32'h0;
    if (we && win) m_mem[a[8:2]] = wd;
    @(posedge clk); @(negedge clk);
    chk(px_out_valid == m_ov, {req, " out_valid"}, 32'(px_out_valid), 32'(m_ov));
    if (m_ov)
      chk({px_out_red, px_out_green, px_out_blue} == m_pix, {req, " color"},
          32'({px_out_red, px_out_green, px_out_blue}), 32'(m_pix));
    chk(bus_rvalid == m_rv, {req, " rvalid"}, 32'(bus_rvalid), 32'(m_rv));
    if (m_rv) chk(bus_rdata == m_rd, {req, " rdata"}, bus_rdata, m_rd);
  endtask

  task automatic idle();
    step(0, 0, 12'h0, 0, 0, 0, 0, 1, "idle");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    chk(px_out_valid == 0, "R10 out_valid", 32'(px_out_valid), 0);
    chk(bus_rvalid == 0, "R10 rvalid", 32'(bus_rvalid), 0);
    step(0, 1, 12'h3FC, 0, 0, 0, 0, 1, "R10 word zero");
    step(0, 0, 12'h0, 0, 1, 8'd255, 0, 1, "R10 lookup zero");
    // R1 write/read at both window edges
    step(1, 0, 12'h200, 32'hDEAD_BEEF, 0, 0, 0, 1, "R1");
    step(1, 0, 12'h3FC, 32'h1234_5678, 0, 0, 0, 1, "R1");
    step(0, 1, 12'h200, 0, 0, 0, 0, 1, "R1");
    step(0, 1, 12'h3FC, 0, 0, 0, 0, 1, "R1");
    // R2 outside window
    step(1, 0, 12'h1FC, 32'hFFFF_FFFF, 0, 0, 0, 1, "R2");
    step(1, 0, 12'h400, 32'hFFFF_FFFF, 0, 0, 0, 1, "R2");
    step(1, 0, 12'h000, 32'hFFFF_FFFF, 0, 0, 0, 1, "R2");
    step(0, 1, 12'h400, 0, 0, 0, 0, 1, "R2 miss read");
    step(0, 1, 12'h200, 0, 0, 0, 0, 1, "R2 word intact");
    step(0, 1, 12'h3FC, 0, 0, 0, 0, 1, "R2 word intact");
    // R3/R4/R5: halves, fields, intensity bit
    step(1, 0, 12'h204, {1'b1, 5'd3, 5'd2, 5'd1, 1'b0, 5'd31, 5'd16, 5'd7}, 0, 0, 0, 1, "R4");
    step(0, 0, 12'h0, 0, 1, 8'd2, 0, 1, "R3 even R4");
    step(0, 0, 12'h0, 0, 1, 8'd3, 0, 1, "R3 odd R5");
    step(1, 0, 12'h204, {1'b0, 5'd3, 5'd2, 5'd1, 1'b1, 5'd31, 5'd16, 5'd7}, 0, 0, 0, 1, "R5");
    step(0, 0, 12'h0, 0, 1, 8'd2, 0, 1, "R5 intensity ignored");
    step(0, 0, 12'h0, 0, 1, 8'd3, 0, 1, "R5 intensity ignored");
    // R9 swap
    step(0, 0, 12'h0, 0, 1, 8'd2, 1, 1, "R9");
    // R6/R7 stall and drain
    step(0, 0, 12'h0, 0, 1, 8'd3, 0, 0, "R6");
    step(0, 0, 12'h0, 0, 1, 8'd2, 0, 0, "R7 held");
    step(0, 0, 12'h0, 0, 1, 8'd2, 1, 0, "R7 held");
    step(0, 0, 12'h0, 0, 0, 8'd2, 0, 1, "R7 drain");
    // R8 same-cycle write and lookup
    step(1, 0, 12'h204, 32'h7C00_001F, 1, 8'd2, 0, 1, "R8 old color");
    step(0, 0, 12'h0, 0, 1, 8'd2, 0, 1, "R8 new color");
    idle();
    // random mix covering R1..R9
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a = 12'($urandom_range(0, 4095)) & 12'hFFC;
      if ($urandom_range(0, 3) != 0) a = {3'b001, a[8:0]};
      step($urandom_range(0, 1), $urandom_range(0, 1), a, $urandom,
           $urandom_range(0, 3) != 0, 8'($urandom), $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, "R3 R6 R8 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule